// File: doc/BRIEF.md
# Host Mailbox Interface

This block is a two-way mailbox between an external host bus and a local processor core that share one clock. The host reaches five registers through a 3-bit address, a read strobe and a write strobe. Words written by the host pass through a holding register into a core-side receive register. Words pushed by the core land in a host-readable register. A status word tells the host which way data can move and carries two flag bits set by the core.

The host can post a command with a 6-bit vector to the core. Until the core takes the command, the vector is locked. An active-low interrupt line tells the host about a pending receive-full or transmit-empty condition, each with its own enable. While the line is active and the host raises its acknowledge input, a read returns a stored interrupt vector.

The host-to-core path is a four-state machine:
- IDLE: both registers are empty.
- STAGED: the holding register is full and the core register is empty.
- CORE: only the core register is full.
- BOTH: both registers are full.

Its transitions are:
- IDLE goes to STAGED on a host data write.
- STAGED goes to CORE on the next clock.
- CORE goes to IDLE on a core take, to BOTH on a host write, or to STAGED on both at once.
- BOTH goes to CORE on a core take, which moves the held word across in the same edge.

The core-to-host path has two states:
- EMPTY goes to FULL on a core push.
- FULL goes to EMPTY on a host data read.

The command machine has two states:
- IDLE goes to PEND on a host command write with the go bit set.
- PEND goes to IDLE on a core take.

Top module: `hostmbx_top`

Register map (`h_addr`):
- 0: interrupt enables. Bit 0 enables receive-full, bit 1 enables transmit-empty.
- 1: status, read only.
- 2: command. Bit 7 is go/busy and bits 5:0 are the vector.
- 3: interrupt vector, 8 bits.
- 4: data. A write goes to the host transmit side and a read returns the host receive side.

Status bits:
- Bit 0: receive full.
- Bit 1: transmit empty.
- Bit 2: path idle.
- Bit 3: request active.
- Bits 5:4: the core flags, with bit 4 holding `c_gflag_in[0]`.
- Bit 6: command busy.

## Requirements
- R1: After reset, status reads 0x0006 (transmit empty and path idle set, everything else zero), `h_irq_n` is 1, `c_rx_valid` is 0 and `c_cmd_pend` is 0.
- R2: A host write to address 4 while transmit empty is 1 clears status bits 1 and 2 at the write edge. The word shows on `c_rx_data` with `c_rx_valid` high after the following edge, and transmit empty returns to 1 at that same edge.
- R3: A host write to address 4 while transmit empty is 0 is dropped and never reaches the core.
- R4: A word written while the core register is full is held, and transmit empty stays 0. At the edge of `c_rx_take` the held word replaces the core word and transmit empty returns to 1.
- R5: `c_tx_push` while status bit 0 is 0 loads `c_tx_data` and sets bit 0. A push while bit 0 is 1 is ignored. A host read of address 4 returns the word and clears bit 0.
- R6: `h_irq_n` is 0 exactly when (receive full AND enable bit 0) OR (transmit empty AND enable bit 1), and status bit 3 equals the inverse of `h_irq_n`.
- R7: A read with `h_ack`=1 while `h_irq_n`=0 returns the interrupt vector (address 3) in bits 7:0 and has no read side effect. With `h_irq_n`=1, `h_ack` changes nothing.
- R8: A write to address 2 with bit 7 set while the command is clear sets busy (status bit 6, `c_cmd_pend`) and loads bits 5:0 into `c_cmd_vec`. A read of address 2 returns busy in bit 7 and the vector in bits 5:0. A write of bit 7 = 0 never clears busy.
- R9: While busy, writes to address 2 leave the vector unchanged. `c_cmd_take` clears busy. Once busy is clear, a write with bit 7 = 0 loads the vector without setting busy.
- R10: `c_gflag_wr` loads both bits of `c_gflag_in` into status bits 5:4 in one edge.
- R11: Status bit 2 is 1 exactly when neither the holding register nor the core register holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 3 | Host register select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_ack | input | 1 | Host interrupt acknowledge (vector fetch) |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, zero when not reading |
| h_irq_n | output | 1 | Active-low host interrupt request |
| c_rx_data | output | DW | Word for the core |
| c_rx_valid | output | 1 | Core receive register holds a word |
| c_rx_take | input | 1 | Core consumes the receive word |
| c_tx_data | input | DW | Core word for the host |
| c_tx_push | input | 1 | Core pushes `c_tx_data` |
| c_tx_ready | output | 1 | Host receive register is empty |
| c_gflag_in | input | 2 | New values for the core flags |
| c_gflag_wr | input | 1 | Load the core flags |
| c_cmd_pend | output | 1 | Host command pending |
| c_cmd_vec | output | VW | Host command vector |
| c_cmd_take | input | 1 | Core accepts the command |

## Verification
The assertions assume the following about the inputs:
- The host never raises `h_rd` and `h_wr` in the same cycle.
- `c_rx_take` comes only while `c_rx_valid` is high, and `c_cmd_take` only while a command is pending.
- A core push and a host data read of a full register do not coincide.

The stimulus keeps to these rules. Each table entry drives exactly one strobe for one cycle, and a take is issued only after the bench has seen the matching valid or pending output. Deliberately illegal actions are aimed only at behaviour the block must tolerate: a write while transmit is not empty, a push while full, and command writes while busy.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;

    typedef enum logic [1:0] {
        H2C_IDLE   = 2'd0,
        H2C_STAGED = 2'd1,
        H2C_CORE   = 2'd2,
        H2C_BOTH   = 2'd3
    } h2c_state_e;

    typedef enum logic {
        C2H_EMPTY = 1'b0,
        C2H_FULL  = 1'b1
    } c2h_state_e;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_PEND = 1'b1
    } cmd_state_e;

    localparam logic [2:0] REG_IEN  = 3'd0;
    localparam logic [2:0] REG_STAT = 3'd1;
    localparam logic [2:0] REG_CMD  = 3'd2;
    localparam logic [2:0] REG_IVEC = 3'd3;
    localparam logic [2:0] REG_DATA = 3'd4;

    localparam int ST_RXF  = 0;
    localparam int ST_TXE  = 1;
    localparam int ST_IDLE = 2;
    localparam int ST_IRQ  = 3;
    localparam int ST_GF0  = 4;
    localparam int ST_GF1  = 5;
    localparam int ST_BUSY = 6;

    localparam int CMD_GO_BIT = 7;

endpackage

// File: rtl/hmb_h2c_path.sv
module hmb_h2c_path
    import hostmbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          core_take,
    output logic [DW-1:0] core_data,
    output logic          core_valid,
    output logic          tx_empty,
    output logic          path_idle
);

    h2c_state_e    state_q, state_d;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] core_q;
    logic          wr_ok;
    logic          move;

    assign wr_ok = wr_en && tx_empty;
    assign move  = (state_q == H2C_STAGED) || (state_q == H2C_BOTH && core_take);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= H2C_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H2C_IDLE:   if (wr_en) state_d = H2C_STAGED;
            H2C_STAGED: state_d = H2C_CORE;
            H2C_CORE: begin
                if (core_take && wr_en)  state_d = H2C_STAGED;
                else if (core_take)      state_d = H2C_IDLE;
                else if (wr_en)          state_d = H2C_BOTH;
            end
            H2C_BOTH:   if (core_take) state_d = H2C_CORE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            core_q <= '0;
        end else begin
            if (wr_ok) hold_q <= wdata;
            if (move)  core_q <= hold_q;
        end
    end

    always_comb begin
        core_data  = core_q;
        core_valid = 1'b0;
        tx_empty   = 1'b0;
        path_idle  = 1'b0;
        unique case (state_q)
            H2C_IDLE:   begin tx_empty = 1'b1; path_idle = 1'b1; end
            H2C_STAGED: ;
            H2C_CORE:   begin tx_empty = 1'b1; core_valid = 1'b1; end
            H2C_BOTH:   core_valid = 1'b1;
        endcase
    end

    // R2
    write_reaches_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && path_idle) |=> ##1 (core_valid && core_data == $past(wdata, 2)));

    // R3
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_empty) |=> $stable(hold_q));

    // R4
    held_word_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !tx_empty && core_take) |=> (core_valid && tx_empty && core_data == $past(hold_q)));

endmodule

// File: rtl/hmb_c2h_path.sv
module hmb_c2h_path
    import hostmbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          host_read,
    output logic [DW-1:0] host_data,
    output logic          full,
    output logic          ready
);

    c2h_state_e    state_q, state_d;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C2H_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C2H_EMPTY: if (push)      state_d = C2H_FULL;
            C2H_FULL:  if (host_read) state_d = C2H_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (push && state_q == C2H_EMPTY) data_q <= push_data;
    end

    always_comb begin
        host_data = data_q;
        unique case (state_q)
            C2H_EMPTY: begin full = 1'b0; ready = 1'b1; end
            C2H_FULL:  begin full = 1'b1; ready = 1'b0; end
        endcase
    end

    // R5
    push_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && ready) |=> (full && host_data == $past(push_data)));

    // R5
    push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(host_data));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_read && full && !push) |=> !full);

endmodule

// File: rtl/hmb_cmd_unit.sv
module hmb_cmd_unit
    import hostmbx_pkg::*;
#(
    parameter int VW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          go,
    input  logic [VW-1:0] vec_in,
    input  logic          take,
    output logic          busy,
    output logic [VW-1:0] vec
);

    cmd_state_e    state_q, state_d;
    logic [VW-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (cmd_wr && go) state_d = CMD_PEND;
            CMD_PEND: if (take)         state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             vec_q <= '0;
        else if (cmd_wr && state_q == CMD_IDLE) vec_q <= vec_in;
    end

    always_comb begin
        vec = vec_q;
        unique case (state_q)
            CMD_IDLE: busy = 1'b0;
            CMD_PEND: busy = 1'b1;
        endcase
    end

    // R9
    vec_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(vec));

    // R8
    zero_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take) |=> busy);

    // R9
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && take) |=> !busy);

endmodule

// File: rtl/hmb_irq_unit.sv
module hmb_irq_unit #(
    parameter int IVW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ien_wr,
    input  logic [1:0]     ien_in,
    input  logic           ivec_wr,
    input  logic [IVW-1:0] ivec_in,
    input  logic           rx_full,
    input  logic           tx_empty,
    output logic [1:0]     ien,
    output logic [IVW-1:0] ivec,
    output logic           irq_act
);

    logic [1:0]     ien_q;
    logic [IVW-1:0] ivec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            ivec_q <= '0;
        end else begin
            if (ien_wr)  ien_q  <= ien_in;
            if (ivec_wr) ivec_q <= ivec_in;
        end
    end

    always_comb begin
        ien     = ien_q;
        ivec    = ivec_q;
        irq_act = (rx_full && ien_q[0]) || (tx_empty && ien_q[1]);
    end

    // R6
    no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 2'b00) |-> !irq_act);

endmodule

// File: rtl/hostmbx_top.sv
module hostmbx_top
    import hostmbx_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VW  = 6,
    parameter int IVW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    h_addr,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic          h_ack,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq_n,
    output logic [DW-1:0] c_rx_data,
    output logic          c_rx_valid,
    input  logic          c_rx_take,
    input  logic [DW-1:0] c_tx_data,
    input  logic          c_tx_push,
    output logic          c_tx_ready,
    input  logic [1:0]    c_gflag_in,
    input  logic          c_gflag_wr,
    output logic          c_cmd_pend,
    output logic [VW-1:0] c_cmd_vec,
    input  logic          c_cmd_take
);

    logic           tx_empty, path_idle, rx_full, irq_act, vec_fetch;
    logic [DW-1:0]  rx_word;
    logic [1:0]     ien;
    logic [IVW-1:0] ivec;
    logic [1:0]     gflag_q;
    logic [DW-1:0]  status;

    assign vec_fetch = h_rd && h_ack && irq_act;

    hmb_h2c_path #(.DW(DW)) h2c_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(h_wr && h_addr == REG_DATA), .wdata(h_wdata),
        .core_take(c_rx_take), .core_data(c_rx_data), .core_valid(c_rx_valid),
        .tx_empty(tx_empty), .path_idle(path_idle)
    );

    hmb_c2h_path #(.DW(DW)) c2h_i (
        .clk(clk), .rst_n(rst_n),
        .push(c_tx_push), .push_data(c_tx_data),
        .host_read(h_rd && h_addr == REG_DATA && !vec_fetch),
        .host_data(rx_word), .full(rx_full), .ready(c_tx_ready)
    );

    hmb_cmd_unit #(.VW(VW)) cmd_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(h_wr && h_addr == REG_CMD), .go(h_wdata[CMD_GO_BIT]),
        .vec_in(h_wdata[VW-1:0]), .take(c_cmd_take),
        .busy(c_cmd_pend), .vec(c_cmd_vec)
    );

    hmb_irq_unit #(.IVW(IVW)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .ien_wr(h_wr && h_addr == REG_IEN), .ien_in(h_wdata[1:0]),
        .ivec_wr(h_wr && h_addr == REG_IVEC), .ivec_in(h_wdata[IVW-1:0]),
        .rx_full(rx_full), .tx_empty(tx_empty),
        .ien(ien), .ivec(ivec), .irq_act(irq_act)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          gflag_q <= 2'b00;
        else if (c_gflag_wr) gflag_q <= c_gflag_in;
    end

    always_comb begin
        status          = '0;
        status[ST_RXF]  = rx_full;
        status[ST_TXE]  = tx_empty;
        status[ST_IDLE] = path_idle;
        status[ST_IRQ]  = irq_act;
        status[ST_GF0]  = gflag_q[0];
        status[ST_GF1]  = gflag_q[1];
        status[ST_BUSY] = c_cmd_pend;
    end

    always_comb begin
        h_rdata = '0;
        if (vec_fetch) begin
            h_rdata[IVW-1:0] = ivec;
        end else if (h_rd) begin
            case (h_addr)
                REG_IEN:  h_rdata[1:0] = ien;
                REG_STAT: h_rdata = status;
                REG_CMD: begin
                    h_rdata[CMD_GO_BIT] = c_cmd_pend;
                    h_rdata[VW-1:0]     = c_cmd_vec;
                end
                REG_IVEC: h_rdata[IVW-1:0] = ivec;
                REG_DATA: h_rdata = rx_word;
                default:  h_rdata = '0;
            endcase
        end
    end

    assign h_irq_n = ~irq_act;

    // R7
    vec_fetch_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && rx_full) |=> rx_full);

    // R10
    gflag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_gflag_wr |=> (status[ST_GF1:ST_GF0] == $past(c_gflag_in)));

    // R11
    idle_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_IDLE] |-> (status[ST_TXE] && !c_rx_valid));

endmodule

// File: tb/hostmbx_tb.sv
module hostmbx_top_tb_top;

    localparam int DW = 16;
    localparam int VW = 6;

    localparam logic [3:0] OP_NOP = 4'd0, OP_WR = 4'd1, OP_RD = 4'd2, OP_VR = 4'd3,
                           OP_CP = 4'd4, OP_CT = 4'd5, OP_CF = 4'd6, OP_CK = 4'd7,
                           OP_CI = 4'd8, OP_CV = 4'd9, OP_CD = 4'd10, OP_CC = 4'd11;

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 52;
    localparam vec_t TBL [0:NV-1] = '{
        '{OP_RD, 3'd1, 16'h0000, 16'h0006, 4'd1},   // R1 reset status
        '{OP_CI, 3'd0, 16'h0000, 16'h0001, 4'd1},   // R1 irq idle
        '{OP_WR, 3'd4, 16'h1234, 16'h0000, 4'd2},
        '{OP_RD, 3'd1, 16'h0000, 16'h0000, 4'd2},   // R2 staged
        '{OP_RD, 3'd1, 16'h0000, 16'h0002, 4'd11},  // R11 core full
        '{OP_CV, 3'd0, 16'h0000, 16'h0001, 4'd2},   // R2
        '{OP_CD, 3'd0, 16'h0000, 16'h1234, 4'd2},   // R2
        '{OP_WR, 3'd4, 16'h5678, 16'h0000, 4'd4},
        '{OP_WR, 3'd4, 16'hDEAD, 16'h0000, 4'd3},   // R3 dropped write
        '{OP_RD, 3'd1, 16'h0000, 16'h0000, 4'd4},   // R4 both full
        '{OP_CD, 3'd0, 16'h0000, 16'h1234, 4'd4},   // R4 old word kept
        '{OP_CT, 3'd0, 16'h0000, 16'h0000, 4'd4},
        '{OP_CD, 3'd0, 16'h0000, 16'h5678, 4'd3},   // R3 DEAD never arrives
        '{OP_RD, 3'd1, 16'h0000, 16'h0002, 4'd4},   // R4
        '{OP_CT, 3'd0, 16'h0000, 16'h0000, 4'd11},
        '{OP_RD, 3'd1, 16'h0000, 16'h0006, 4'd11},  // R11 idle again
        '{OP_CP, 3'd0, 16'h00A5, 16'h0000, 4'd5},
        '{OP_CP, 3'd0, 16'h00FF, 16'h0000, 4'd5},   // R5 ignored push
        '{OP_RD, 3'd1, 16'h0000, 16'h0007, 4'd5},   // R5
        '{OP_WR, 3'd0, 16'h0001, 16'h0000, 4'd6},
        '{OP_CI, 3'd0, 16'h0000, 16'h0000, 4'd6},   // R6 rx irq
        '{OP_RD, 3'd1, 16'h0000, 16'h000F, 4'd6},   // R6 mirror bit
        '{OP_WR, 3'd3, 16'h0042, 16'h0000, 4'd7},
        '{OP_VR, 3'd1, 16'h0000, 16'h0042, 4'd7},   // R7 vector fetch
        '{OP_RD, 3'd1, 16'h0000, 16'h000F, 4'd7},   // R7 no side effect
        '{OP_RD, 3'd4, 16'h0000, 16'h00A5, 4'd5},   // R5 host read
        '{OP_RD, 3'd1, 16'h0000, 16'h0006, 4'd5},   // R5 cleared
        '{OP_CI, 3'd0, 16'h0000, 16'h0001, 4'd6},   // R6
        '{OP_WR, 3'd0, 16'h0002, 16'h0000, 4'd6},
        '{OP_CI, 3'd0, 16'h0000, 16'h0000, 4'd6},   // R6 tx irq
        '{OP_WR, 3'd4, 16'h0BEE, 16'h0000, 4'd6},
        '{OP_CI, 3'd0, 16'h0000, 16'h0001, 4'd6},   // R6 write clears
        '{OP_CI, 3'd0, 16'h0000, 16'h0000, 4'd6},   // R6 back after move
        '{OP_CD, 3'd0, 16'h0000, 16'h0BEE, 4'd2},   // R2
        '{OP_CT, 3'd0, 16'h0000, 16'h0000, 4'd2},
        '{OP_WR, 3'd0, 16'h0000, 16'h0000, 4'd6},
        '{OP_CF, 3'd0, 16'h0003, 16'h0000, 4'd10},
        '{OP_RD, 3'd1, 16'h0000, 16'h0036, 4'd10},  // R10 both flags
        '{OP_CF, 3'd0, 16'h0001, 16'h0000, 4'd10},
        '{OP_RD, 3'd1, 16'h0000, 16'h0016, 4'd10},  // R10 one flag
        '{OP_WR, 3'd2, 16'h0095, 16'h0000, 4'd8},
        '{OP_CC, 3'd0, 16'h0000, 16'h0055, 4'd8},   // R8 pend + vec
        '{OP_RD, 3'd2, 16'h0000, 16'h0095, 4'd8},   // R8 readback
        '{OP_WR, 3'd2, 16'h0000, 16'h0000, 4'd8},
        '{OP_WR, 3'd2, 16'h00AA, 16'h0000, 4'd9},
        '{OP_CC, 3'd0, 16'h0000, 16'h0055, 4'd9},   // R9 locked
        '{OP_RD, 3'd1, 16'h0000, 16'h0056, 4'd8},   // R8 busy bit
        '{OP_CK, 3'd0, 16'h0000, 16'h0000, 4'd9},
        '{OP_CC, 3'd0, 16'h0000, 16'h0015, 4'd9},   // R9 taken
        '{OP_WR, 3'd2, 16'h002A, 16'h0000, 4'd9},
        '{OP_RD, 3'd2, 16'h0000, 16'h002A, 4'd9},   // R9 vector only
        '{OP_VR, 3'd1, 16'h0000, 16'h0016, 4'd7}    // R7 ack without irq
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    h_addr = '0;
    logic          h_rd = 1'b0, h_wr = 1'b0, h_ack = 1'b0;
    logic [DW-1:0] h_wdata = '0;
    logic [DW-1:0] h_rdata;
    logic          h_irq_n;
    logic [DW-1:0] c_rx_data;
    logic          c_rx_valid;
    logic          c_rx_take = 1'b0;
    logic [DW-1:0] c_tx_data = '0;
    logic          c_tx_push = 1'b0;
    logic          c_tx_ready;
    logic [1:0]    c_gflag_in = '0;
    logic          c_gflag_wr = 1'b0;
    logic          c_cmd_pend;
    logic [VW-1:0] c_cmd_vec;
    logic          c_cmd_take = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    hostmbx_top #(.DW(DW), .VW(VW), .IVW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
        .h_ack(h_ack), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq_n(h_irq_n),
        .c_rx_data(c_rx_data), .c_rx_valid(c_rx_valid), .c_rx_take(c_rx_take),
        .c_tx_data(c_tx_data), .c_tx_push(c_tx_push), .c_tx_ready(c_tx_ready),
        .c_gflag_in(c_gflag_in), .c_gflag_wr(c_gflag_wr),
        .c_cmd_pend(c_cmd_pend), .c_cmd_vec(c_cmd_vec), .c_cmd_take(c_cmd_take)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input int req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        @(negedge clk);
        h_rd = 1'b0; h_wr = 1'b0; h_ack = 1'b0; c_rx_take = 1'b0;
        c_tx_push = 1'b0; c_gflag_wr = 1'b0; c_cmd_take = 1'b0;
        h_addr = v.addr; h_wdata = v.data;
        case (v.op)
            OP_WR: h_wr = 1'b1;
            OP_RD: h_rd = 1'b1;
            OP_VR: begin h_rd = 1'b1; h_ack = 1'b1; end
            OP_CP: begin c_tx_push = 1'b1; c_tx_data = v.data; end
            OP_CT: c_rx_take = 1'b1;
            OP_CF: begin c_gflag_wr = 1'b1; c_gflag_in = v.data[1:0]; end
            OP_CK: c_cmd_take = 1'b1;
            default: ;
        endcase
        #2;
        case (v.op)
            OP_RD, OP_VR: chk(h_rdata, v.exp, int'(v.req));
            OP_CI: chk({15'd0, h_irq_n}, v.exp, int'(v.req));
            OP_CV: chk({15'd0, c_rx_valid}, v.exp, int'(v.req));
            OP_CD: chk(c_rx_data, v.exp, int'(v.req));
            OP_CC: chk({9'd0, c_cmd_pend, c_cmd_vec}, v.exp, int'(v.req));
            default: ;
        endcase
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_op(TBL[i]);
        run_op('{OP_NOP, 3'd0, 16'h0, 16'h0, 4'd0});

        // R1: reset in the middle of traffic
        run_op('{OP_CP, 3'd0, 16'h0033, 16'h0, 4'd1});
        run_op('{OP_WR, 3'd4, 16'h0044, 16'h0, 4'd1});
        run_op('{OP_WR, 3'd2, 16'h0081, 16'h0, 4'd1});
        run_op('{OP_WR, 3'd0, 16'h0003, 16'h0, 4'd1});
        run_op('{OP_NOP, 3'd0, 16'h0, 16'h0, 4'd1});
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        run_op('{OP_RD, 3'd1, 16'h0000, 16'h0006, 4'd1});
        run_op('{OP_CI, 3'd0, 16'h0000, 16'h0001, 4'd1});
        run_op('{OP_CV, 3'd0, 16'h0000, 16'h0000, 4'd1});
        run_op('{OP_CC, 3'd0, 16'h0000, 16'h0000, 4'd1});
        run_op('{OP_NOP, 3'd0, 16'h0, 16'h0, 4'd0});

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule